// File: doc/BRIEF.md
# PS/2 Mouse Movement Packet Receiver

This block listens to the clock and data lines of a PS/2 pointing device and turns each three-frame movement packet into a decoded result. Both lines are brought into the system clock domain and filtered. A data bit is taken on every falling edge of the filtered device clock. Each 11-bit frame is checked for framing and parity. The first frame is the status byte, the second is horizontal motion and the third is vertical motion. From these the block builds signed 9-bit deltas, two overflow flags and two button states.

A clean packet produces a one-cycle `pkt_valid` strobe, and the decoded fields are held until the next clean packet. A packet that fails any check produces a one-cycle `pkt_err` strobe instead, and no result is issued for it. The device sends at its own pace and cannot be stalled, because clock inhibit is not part of this block. For that reason the result port has no ready input and applies no back-pressure: a consumer must take the result in the cycle `pkt_valid` is high, or read the held fields later. A packet left unfinished for about 2 ms is abandoned, and the receiver then waits for a new status frame.

Top module: `ps2_mouse_rx`

## Requirements
- R1: After reset, `pkt_valid` and `pkt_err` are low and every decoded output is zero.
- R2: Each frame is one start bit, then eight data bits sent least-significant first, then a parity bit, then a stop bit. Each bit is taken on a falling edge of the filtered device clock.
- R3: A frame is accepted only if its start bit is 0, its stop bit is 1, and its eight data bits together with the parity bit hold an odd number of ones.
- R4: In the status byte, bit 3 must be 1. Bit 0 is the left button and bit 1 is the right button (1 means pressed). Bit 4 is the X sign, bit 5 is the Y sign, bit 6 is the X overflow and bit 7 is the Y overflow. A status byte with bit 3 equal to 0 is an error.
- R5: For a clean packet, `pkt_dx` is {X sign, X byte} and `pkt_dy` is {Y sign, Y byte}, both as 9-bit two's-complement values. The button and overflow outputs copy their status bits, and `pkt_valid` pulses exactly once.
- R6: The first failed check in a packet pulses `pkt_err` exactly once. All frames of that packet are still consumed, later failures in the same packet raise no further strobe, no `pkt_valid` is issued for it, and the next packet decodes normally.
- R7: `pkt_valid` and `pkt_err` are each high for one cycle at most, and never both in the same cycle.
- R8: If no falling clock edge arrives for `TIMEOUT_CYCLES` cycles in the middle of a packet, the partial packet is dropped without an error. The next frame is then treated as a status frame.
- R9: A low pulse on the device clock that lasts fewer than `FILTER_LEN` system cycles is ignored.
- R10: The decoded outputs keep their values in every cycle in which `pkt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_in | input | 1 | Device clock line, idle high |
| ps2_data_in | input | 1 | Device data line, idle high |
| pkt_valid | output | 1 | One-cycle strobe: a clean packet was decoded |
| pkt_dx | output | 9 | Signed X movement, right is positive |
| pkt_dy | output | 9 | Signed Y movement, up is positive |
| pkt_btn_left | output | 1 | Left button pressed |
| pkt_btn_right | output | 1 | Right button pressed |
| pkt_x_ovf | output | 1 | X movement overflowed |
| pkt_y_ovf | output | 1 | Y movement overflowed |
| pkt_err | output | 1 | One-cycle strobe: the packet failed a check |

## Verification
The assertions assume that the device clock spends much longer than `FILTER_LEN` cycles in each phase. They also assume that gaps inside a packet stay shorter than `TIMEOUT_CYCLES`, so frames are never closer than a few tens of cycles. The stimulus holds every half period at 20 system cycles and sends frames back to back. Its only deliberate glitch is two cycles long, and its only deliberate stall is longer than the timeout. Because of this, the one-cycle strobe properties and the output-hold properties are tested only within the spacing a real device produces.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;
  localparam int FRAME_BITS = 11;
  localparam int BYTE_BITS  = 8;

  typedef enum logic [1:0] {
    SLOT_STAT = 2'd0,
    SLOT_XMOV = 2'd1,
    SLOT_YMOV = 2'd2
  } slot_e;

  // status byte field positions
  localparam int ST_LEFT  = 0;
  localparam int ST_RIGHT = 1;
  localparam int ST_ONE   = 3;
  localparam int ST_XSGN  = 4;
  localparam int ST_YSGN  = 5;
  localparam int ST_XOVF  = 6;
  localparam int ST_YOVF  = 7;
endpackage

// File: rtl/ps2m_line_filter.sv
module ps2m_line_filter #(
  parameter int FILTER_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(FILTER_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_cnt;
  logic          filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      run_cnt <= '0;
      filt_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_in};
      if (sync_q[1] == filt_q) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(FILTER_LEN - 1)) begin
        filt_q  <= sync_q[1];
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign line_out = filt_q;

  // R9: the filtered level only moves toward what the synchronizer last showed
  assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q));
endmodule

// File: rtl/ps2m_frame_rx.sv
module ps2m_frame_rx #(
  parameter int TIMEOUT_CYCLES = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_f,
  input  logic       data_f,
  input  logic       hold_busy,
  output logic       frame_done,
  output logic [7:0] frame_byte,
  output logic       frame_ok,
  output logic       abort
);
  import ps2m_pkg::*;
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);

  logic                    clk_d;
  logic                    fall;
  logic [BW-1:0]           bit_cnt;
  logic [FRAME_BITS-2:0]   sh_q;
  logic [FRAME_BITS-1:0]   nx;
  logic [TW-1:0]           idle_cnt;
  logic                    busy;

  assign fall = clk_d & ~clk_f;
  assign nx   = {data_f, sh_q};
  assign busy = (bit_cnt != '0) | hold_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_d      <= 1'b1;
      bit_cnt    <= '0;
      sh_q       <= '0;
      idle_cnt   <= '0;
      frame_done <= 1'b0;
      frame_byte <= '0;
      frame_ok   <= 1'b0;
      abort      <= 1'b0;
    end else begin
      clk_d      <= clk_f;
      frame_done <= 1'b0;
      abort      <= 1'b0;
      if (fall) begin
        idle_cnt <= '0;
        sh_q     <= nx[FRAME_BITS-1:1];
        if (bit_cnt == BW'(FRAME_BITS - 1)) begin
          bit_cnt    <= '0;
          frame_done <= 1'b1;
          frame_byte <= nx[BYTE_BITS:1];
          frame_ok   <= ~nx[0] & nx[FRAME_BITS-1] & (^nx[BYTE_BITS+1:1]);
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (!busy) begin
        idle_cnt <= '0;
      end else if (idle_cnt == TW'(TIMEOUT_CYCLES - 1)) begin
        idle_cnt <= '0;
        bit_cnt  <= '0;
        abort    <= 1'b1;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  // R2: the bit position never leaves the frame
  assert_bit_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < BW'(FRAME_BITS));
  // R8: an abort leaves the bit counter at the start of a frame
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (bit_cnt == '0) && !frame_done);
endmodule

// File: rtl/ps2m_packet_asm.sv
module ps2m_packet_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  logic [7:0] frame_byte,
  input  logic       frame_ok,
  input  logic       abort,
  output logic       mid_packet,
  output logic       out_valid,
  output logic [8:0] out_dx,
  output logic [8:0] out_dy,
  output logic       out_left,
  output logic       out_right,
  output logic       out_xovf,
  output logic       out_yovf,
  output logic       out_err
);
  import ps2m_pkg::*;

  slot_e      slot_q;
  logic       bad_q;
  logic [7:0] stat_q;
  logic [7:0] xb_q;
  logic       good;

  assign good       = frame_ok & ((slot_q != SLOT_STAT) | frame_byte[ST_ONE]);
  assign mid_packet = (slot_q != SLOT_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q    <= SLOT_STAT;
      bad_q     <= 1'b0;
      stat_q    <= '0;
      xb_q      <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_dx    <= '0;
      out_dy    <= '0;
      out_left  <= 1'b0;
      out_right <= 1'b0;
      out_xovf  <= 1'b0;
      out_yovf  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      if (abort) begin
        slot_q <= SLOT_STAT;
        bad_q  <= 1'b0;
      end else if (frame_done) begin
        if (!good && !bad_q) out_err <= 1'b1;
        unique case (slot_q)
          SLOT_STAT: begin
            stat_q <= frame_byte;
            bad_q  <= ~good;
            slot_q <= SLOT_XMOV;
          end
          SLOT_XMOV: begin
            xb_q   <= frame_byte;
            bad_q  <= bad_q | ~good;
            slot_q <= SLOT_YMOV;
          end
          default: begin
            slot_q <= SLOT_STAT;
            bad_q  <= 1'b0;
            if (good && !bad_q) begin
              out_valid <= 1'b1;
              out_dx    <= {stat_q[ST_XSGN], xb_q};
              out_dy    <= {stat_q[ST_YSGN], frame_byte};
              out_left  <= stat_q[ST_LEFT];
              out_right <= stat_q[ST_RIGHT];
              out_xovf  <= stat_q[ST_XOVF];
              out_yovf  <= stat_q[ST_YOVF];
            end
          end
        endcase
      end
    end
  end

  // R7: strobes are single-cycle and mutually exclusive
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |=> !out_err);
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));
  // R10: decoded fields hold while no result is issued
  assert_hold_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_dx) && $stable(out_dy) && $stable(out_left)
                   && $stable(out_right) && $stable(out_xovf) && $stable(out_yovf));
  // R8: an abort returns the assembler to the status slot
  assert_abort_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (slot_q == SLOT_STAT) && !out_valid);
  // R6: a result only follows a Y frame
  assert_valid_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(frame_done) && $past(frame_ok));
endmodule

// File: rtl/ps2_mouse_rx.sv
module ps2_mouse_rx #(
  parameter int FILTER_LEN     = 4,
  parameter int TIMEOUT_CYCLES = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_data_in,
  output logic       pkt_valid,
  output logic [8:0] pkt_dx,
  output logic [8:0] pkt_dy,
  output logic       pkt_btn_left,
  output logic       pkt_btn_right,
  output logic       pkt_x_ovf,
  output logic       pkt_y_ovf,
  output logic       pkt_err
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic              frame_done;
  logic [7:0]        frame_byte;
  logic              frame_ok;
  logic              abort;
  logic              mid_packet;

  assign raw_lines = {ps2_data_in, ps2_clk_in};

  generate
    for (genvar li = 0; li < NLINES; li++) begin : g_line
      ps2m_line_filter #(.FILTER_LEN(FILTER_LEN)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (raw_lines[li]),
        .line_out(filt_lines[li])
      );
    end
  endgenerate

  ps2m_frame_rx #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_f     (filt_lines[0]),
    .data_f    (filt_lines[1]),
    .hold_busy (mid_packet),
    .frame_done(frame_done),
    .frame_byte(frame_byte),
    .frame_ok  (frame_ok),
    .abort     (abort)
  );

  ps2m_packet_asm u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(frame_done),
    .frame_byte(frame_byte),
    .frame_ok  (frame_ok),
    .abort     (abort),
    .mid_packet(mid_packet),
    .out_valid (pkt_valid),
    .out_dx    (pkt_dx),
    .out_dy    (pkt_dy),
    .out_left  (pkt_btn_left),
    .out_right (pkt_btn_right),
    .out_xovf  (pkt_x_ovf),
    .out_yovf  (pkt_y_ovf),
    .out_err   (pkt_err)
  );
endmodule

// File: tb/ps2_mouse_rx_bench.sv
module ps2_mouse_rx_bench;
  localparam int FLEN = 4;
  localparam int TOUT = 600;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps_clk = 1'b1;
  logic ps_dat = 1'b1;
  logic       pkt_valid, pkt_err;
  logic [8:0] pkt_dx, pkt_dy;
  logic       pkt_btn_left, pkt_btn_right, pkt_x_ovf, pkt_y_ovf;

  int total = 0;
  int bad = 0;
  int n_valid = 0;
  int n_err = 0;
  int n_wide = 0;
  bit prev_v = 1'b0;
  bit prev_e = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ps2_mouse_rx #(.FILTER_LEN(FLEN), .TIMEOUT_CYCLES(TOUT)) u_ps2_mouse_rx (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(ps_clk), .ps2_data_in(ps_dat),
    .pkt_valid(pkt_valid), .pkt_dx(pkt_dx), .pkt_dy(pkt_dy),
    .pkt_btn_left(pkt_btn_left), .pkt_btn_right(pkt_btn_right),
    .pkt_x_ovf(pkt_x_ovf), .pkt_y_ovf(pkt_y_ovf), .pkt_err(pkt_err)
  );

  // strobe monitor, sampled on the inactive edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_valid) n_valid++;
      if (pkt_err) n_err++;
      if ((pkt_valid && prev_v) || (pkt_err && prev_e) || (pkt_valid && pkt_err)) n_wide++;
      prev_v = pkt_valid;
      prev_e = pkt_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    ps_dat = b;
    wait_sys(HALF);
    ps_clk = 1'b0;
    wait_sys(HALF);
    ps_clk = 1'b1;
    if (glitch) begin
      wait_sys(5);
      ps_clk = 1'b0;
      wait_sys(2);
      ps_clk = 1'b1;
    end
  endtask

  // kind: 0 clean, 1 bad start, 2 bad parity, 3 bad stop
  task automatic send_frame(input logic [7:0] b, input int kind, input bit glitch);
    send_bit(kind == 1, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i], glitch && i == 0);
    send_bit((~^b) ^ (kind == 2), 1'b0);
    send_bit(kind != 3, 1'b0);
  endtask

  task automatic send_packet(input logic [7:0] st, input logic [7:0] xb, input logic [7:0] yb,
                             input int k0, input int k1, input int k2, input bit glitch);
    send_frame(st, k0, 1'b0);
    send_frame(xb, k1, glitch);
    send_frame(yb, k2, 1'b0);
    ps_dat = 1'b1;
    wait_sys(HALF + 10);
  endtask

  function automatic logic [8:0] exp_delta(input bit sgn, input logic [7:0] mag);
    return {sgn, mag};
  endfunction

  // check one clean packet end to end
  task automatic good_packet(input logic [7:0] st, input logic [7:0] xb, input logic [7:0] yb,
                             input bit glitch, input string req);
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    send_packet(st, xb, yb, 0, 0, 0, glitch);
    chk(n_valid - v0 == 1, req, n_valid - v0, 1);
    chk(n_err == e0, req, n_err - e0, 0);
    chk(pkt_dx == exp_delta(st[4], xb), {req, " R5 dx"}, pkt_dx, exp_delta(st[4], xb));
    chk(pkt_dy == exp_delta(st[5], yb), {req, " R5 dy"}, pkt_dy, exp_delta(st[5], yb));
    chk({pkt_y_ovf, pkt_x_ovf, pkt_btn_right, pkt_btn_left} == {st[7], st[6], st[1], st[0]},
        {req, " R4 flags"}, {pkt_y_ovf, pkt_x_ovf, pkt_btn_right, pkt_btn_left},
        {st[7], st[6], st[1], st[0]});
  endtask

  task automatic bad_packet(input logic [7:0] st, input int k0, input int k1, input int k2,
                            input string req);
    int v0, e0;
    logic [8:0] dx0;
    v0 = n_valid; e0 = n_err; dx0 = pkt_dx;
    send_packet(st, 8'h11, 8'h22, k0, k1, k2, 1'b0);
    chk(n_err - e0 == 1, {req, " R6 one err"}, n_err - e0, 1);
    chk(n_valid == v0, {req, " R6 no valid"}, n_valid - v0, 0);
    chk(pkt_dx == dx0, {req, " R10 held"}, pkt_dx, dx0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    wait_sys(10);
    // R1 reset state
    chk({pkt_valid, pkt_err, pkt_dx, pkt_dy, pkt_btn_left, pkt_btn_right, pkt_x_ovf, pkt_y_ovf} == 0,
        "R1 reset outputs", {pkt_dx, pkt_dy}, 0);
    rst_n = 1'b1;
    wait_sys(10);
    chk(pkt_valid == 0 && pkt_err == 0, "R1 after reset", {pkt_valid, pkt_err}, 0);

    // R2/R5 directed: positive motion, left button
    good_packet(8'b0000_1001, 8'h05, 8'h03, 1'b0, "R2 directed pos");
    // negative deltas, both overflows, right button
    good_packet(8'b1111_1010, 8'h80, 8'hFF, 1'b0, "R5 directed neg");
    // extremes of LSB-first ordering
    good_packet(8'b0010_1000, 8'h01, 8'h80, 1'b0, "R2 bit order");

    // random clean packets
    for (int n = 0; n < 16; n++) begin
      logic [7:0] st, xb, yb;
      st = 8'($urandom);
      st[3] = 1'b1;
      st[2] = 1'b0;
      xb = 8'($urandom);
      yb = 8'($urandom);
      good_packet(st, xb, yb, 1'b0, "R5 random");
    end

    // R3 framing faults in each frame, R6 recovery
    bad_packet(8'h08, 1, 0, 0, "R3 bad start status");
    good_packet(8'h19, 8'h7F, 8'h40, 1'b0, "R6 recover1");
    bad_packet(8'h08, 0, 2, 0, "R3 bad parity x");
    bad_packet(8'h08, 0, 0, 3, "R3 bad stop y");
    good_packet(8'h2A, 8'hC3, 8'h3C, 1'b0, "R6 recover2");
    // R6 two faulty frames give one strobe
    bad_packet(8'h08, 0, 2, 3, "R6 double fault");
    // R4 status bit 3 clear
    bad_packet(8'h01, 0, 0, 0, "R4 status bit3");
    good_packet(8'h09, 8'h10, 8'h20, 1'b0, "R4 recover");

    // R8 stall mid-packet then a clean packet
    begin
      int v0, e0;
      v0 = n_valid; e0 = n_err;
      send_frame(8'h39, 0, 1'b0);
      for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
      ps_dat = 1'b1;
      wait_sys(TOUT + 200);
      chk(n_err == e0 && n_valid == v0, "R8 stall silent", n_err - e0, 0);
      good_packet(8'h1B, 8'hF0, 8'h0F, 1'b0, "R8 after stall");
    end

    // R9 short clock glitch ignored
    good_packet(8'h0A, 8'h55, 8'hAA, 1'b1, "R9 glitch");

    // R7 strobe width over the whole run
    chk(n_wide == 0, "R7 strobe width", n_wide, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule